// File: doc/BRIEF.md
# High-Frequency Clock Request Gating Controller

This block sits between clock consumers and an external high-frequency clock source. The consumers raise a shared request line, which idles low through a weak pull-down. Optional secondary sleep-control lines can also count as requests, each only when its own enable bit is set. Any active request drives a provider-enable output high in the same cycle, with no register on the path, so the external clock source can start at once. The block then counts a programmable number of 32.768 kHz cycles for that source to settle. Only after the count does it open a glitch-free gate that passes the high-frequency clock to the consumers.

The control logic is a four-state machine clocked by the 32 kHz timebase. The states are `ST_IDLE`, `ST_SETTLE`, `ST_RUN` and `ST_CLOSE`, linked by five transitions:
- request (IDLE→SETTLE, loads the timer);
- abort (SETTLE→IDLE, the request was withdrawn while settling);
- expire (SETTLE→RUN, opens the gate and reloads the timer);
- drop (RUN→CLOSE, all requests withdrawn);
- closed (CLOSE→IDLE, the gate is confirmed shut).

The gate-open command reaches the high-frequency domain through a synchronizer. There the gate register changes only while the clock is low. The gate state returns to the 32 kHz domain through a second synchronizer, so the provider enable is released only after the gate is shut.

A single configuration write port loads three settings in the same cycle: the settling count, the output drive-strength bit and the sleep-request enables.

Top module: `hfclk_req_ctrl`

## Requirements
- R1: `prov_en` is high in the same cycle as any enabled request (`req_in`, or `sleep_req[i]` with its enable set), with no clock edge between them.
- R2: A secondary request `sleep_req[i]` takes effect only when `cfg_sleep_en[i]` has been written as 1. All enables reset to 0. A disabled sleep request leaves `prov_en` low and produces no pulse on `hf_clk_out`.
- R3: With settle count N, the state machine samples the request at slow edge k and opens the gate at slow edge k+N. A count of 0 behaves like 1. No pulse appears on `hf_clk_out` before edge k+N, and pulses appear within one slow cycle after it. The gate is open only while `prov_en` is high.
- R4: The settle count resets to 328 slow cycles, the worst-case 10 ms.
- R5: The timer reloads on every gate opening, so each later request waits the full programmed count again.
- R6: A request withdrawn while settling returns the block to idle at the slow edge that samples the withdrawal. The gate never opens. Withdrawal has priority over expiry when both fall on the same edge.
- R7: When all requests are withdrawn in the running state, sampled at slow edge m, no pulse appears on `hf_clk_out` after edge m+1. `prov_en` stays high through edge m+2 and falls at edge m+3, never while the gate is reported open.
- R8: Every high pulse on `hf_clk_out` lasts the full high phase of `clk_hf`, so the gate produces no runt pulses.
- R9: `drive_hi` resets to 0 (low drive) and takes the value of `cfg_drive` at the slow edge where `cfg_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_s | input | 1 | 32.768 kHz timebase |
| clk_hf | input | 1 | High-frequency clock from the provider |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| req_in | input | 1 | Wired-OR clock request, idles low |
| sleep_req | input | NSEC | Secondary sleep-control request lines |
| cfg_we | input | 1 | Configuration write strobe, sampled on clk_s |
| cfg_settle | input | SETTLE_W | Settling count in slow cycles |
| cfg_drive | input | 1 | Drive strength: 0 low, 1 high |
| cfg_sleep_en | input | NSEC | Per-line enables for the sleep requests |
| prov_en | output | 1 | Enable to the external clock provider |
| hf_clk_out | output | 1 | Gated high-frequency clock |
| drive_hi | output | 1 | Selected drive strength for the clock output buffer |

## Verification
Two outcomes can fall on the same slow edge: expiry of the settling count and withdrawal of the request. The bench holds a request for a count of three and releases it so that the withdrawal is sampled on the very edge where the count would expire. It judges the outcome by checking that `prov_en` is low after that edge and that no pulse ever reaches `hf_clk_out`. The bench also sweeps every settle count from 0 to 5 against every request source, twice in a row, to confirm the reload.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2,
        ST_CLOSE  = 2'd3
    } hcr_state_e;

endpackage

// File: rtl/hcr_sync.sv
module hcr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sr_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= {sr_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr_q[STAGES-1];

endmodule

// File: rtl/hcr_req_merge.sv
module hcr_req_merge #(
    parameter int NSEC = 2
) (
    input  logic            req_in,
    input  logic [NSEC-1:0] sleep_req,
    input  logic [NSEC-1:0] sleep_en,
    output logic            req_any
);

    logic [NSEC-1:0] gated;

    for (genvar i = 0; i < NSEC; i++) begin : g_sec
        assign gated[i] = sleep_req[i] & sleep_en[i];
    end

    assign req_any = req_in | (|gated);

endmodule

// File: rtl/hcr_settle_timer.sv
module hcr_settle_timer #(
    parameter int SETTLE_W       = 9,
    parameter int DEFAULT_SETTLE = 328
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [SETTLE_W-1:0] cfg_val,
    input  logic                load,
    input  logic                dec,
    output logic                expired
);

    localparam logic [SETTLE_W-1:0] RST_VAL = SETTLE_W'(DEFAULT_SETTLE);
    localparam logic [SETTLE_W-1:0] ONE     = SETTLE_W'(1);

    logic [SETTLE_W-1:0] reload_q;
    logic [SETTLE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= RST_VAL;
            cnt_q    <= RST_VAL;
        end else begin
            if (cfg_we) reload_q <= cfg_val;
            if (load)     cnt_q <= reload_q;
            else if (dec) cnt_q <= cnt_q - ONE;
        end
    end

    // a count of zero is treated the same as one
    assign expired = (cnt_q <= ONE);

endmodule

// File: rtl/hcr_fsm.sv
module hcr_fsm
    import hcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_any,
    input  logic       expired,
    input  logic       gate_ack,
    output hcr_state_e state_q,
    output logic       load,
    output logic       dec,
    output logic       open_req,
    output logic       prov_hold
);

    hcr_state_e state_d;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        dec     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_any) begin              // request
                    state_d = ST_SETTLE;
                    load    = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (!req_any) begin             // abort, wins over expiry
                    state_d = ST_IDLE;
                end else if (expired) begin     // expire, reload for next time
                    state_d = ST_RUN;
                    load    = 1'b1;
                end else begin
                    dec = 1'b1;
                end
            end
            ST_RUN: begin
                if (!req_any) state_d = ST_CLOSE;   // drop
            end
            ST_CLOSE: begin
                if (!gate_ack) state_d = ST_IDLE;   // closed
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_req  <= 1'b0;
            prov_hold <= 1'b0;
        end else begin
            open_req  <= (state_d == ST_RUN);
            prov_hold <= (state_d != ST_IDLE);
        end
    end

endmodule

// File: rtl/hcr_gate.sv
module hcr_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_hf,
    input  logic rst_n,
    input  logic open_req,
    output logic open_s,
    output logic gate_q,
    output logic clk_out
);

    hcr_sync #(.STAGES(SYNC_STAGES)) u_open_sync (
        .clk   (clk_hf),
        .rst_n (rst_n),
        .d     (open_req),
        .q     (open_s)
    );

    // updated on the falling edge so the enable only moves while the clock is low
    always_ff @(negedge clk_hf or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= open_s;
    end

    assign clk_out = clk_hf & gate_q;

endmodule

// File: rtl/hfclk_req_ctrl.sv
module hfclk_req_ctrl
    import hcr_pkg::*;
#(
    parameter int NSEC           = 2,
    parameter int SETTLE_W       = 9,
    parameter int DEFAULT_SETTLE = 328,
    parameter int SYNC_STAGES    = 2
) (
    input  logic                clk_s,
    input  logic                clk_hf,
    input  logic                rst_n,
    input  logic                req_in,
    input  logic [NSEC-1:0]     sleep_req,
    input  logic                cfg_we,
    input  logic [SETTLE_W-1:0] cfg_settle,
    input  logic                cfg_drive,
    input  logic [NSEC-1:0]     cfg_sleep_en,
    output logic                prov_en,
    output logic                hf_clk_out,
    output logic                drive_hi
);

    logic [NSEC-1:0] sleep_en_q;
    logic            drive_q;
    logic            req_any;
    logic            expired;
    logic            load;
    logic            dec;
    logic            open_req;
    logic            prov_hold;
    logic            open_s;
    logic            gate_q;
    logic            gate_ack;
    hcr_state_e      state_q;

    always_ff @(posedge clk_s or negedge rst_n) begin
        if (!rst_n) begin
            sleep_en_q <= '0;
            drive_q    <= 1'b0;
        end else if (cfg_we) begin
            sleep_en_q <= cfg_sleep_en;
            drive_q    <= cfg_drive;
        end
    end

    hcr_req_merge #(.NSEC(NSEC)) u_merge (
        .req_in    (req_in),
        .sleep_req (sleep_req),
        .sleep_en  (sleep_en_q),
        .req_any   (req_any)
    );

    hcr_settle_timer #(
        .SETTLE_W       (SETTLE_W),
        .DEFAULT_SETTLE (DEFAULT_SETTLE)
    ) u_timer (
        .clk     (clk_s),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_val (cfg_settle),
        .load    (load),
        .dec     (dec),
        .expired (expired)
    );

    hcr_fsm u_fsm (
        .clk       (clk_s),
        .rst_n     (rst_n),
        .req_any   (req_any),
        .expired   (expired),
        .gate_ack  (gate_ack),
        .state_q   (state_q),
        .load      (load),
        .dec       (dec),
        .open_req  (open_req),
        .prov_hold (prov_hold)
    );

    hcr_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk_hf   (clk_hf),
        .rst_n    (rst_n),
        .open_req (open_req),
        .open_s   (open_s),
        .gate_q   (gate_q),
        .clk_out  (hf_clk_out)
    );

    hcr_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk_s),
        .rst_n (rst_n),
        .d     (gate_q),
        .q     (gate_ack)
    );

    assign prov_en  = prov_hold | req_any;
    assign drive_hi = drive_q;

endmodule

// File: rtl/hcr_checker.sv
module hcr_checker
    import hcr_pkg::*;
(
    input logic       clk_s,
    input logic       rst_n,
    input logic       req_in,
    input logic       cfg_we,
    input logic       cfg_drive,
    input logic       prov_en,
    input logic       drive_hi,
    input logic       open_req,
    input logic       gate_ack,
    input hcr_state_e state_q
);

    // R1
    req_raises_enable_chk: assert property (@(posedge clk_s) disable iff (!rst_n)
        req_in |-> prov_en);

    // R3
    open_under_enable_chk: assert property (@(posedge clk_s) disable iff (!rst_n)
        open_req |-> prov_en);

    // R6
    settle_gate_shut_chk: assert property (@(posedge clk_s) disable iff (!rst_n)
        (state_q == ST_SETTLE) |-> !gate_ack);

    // R7
    enable_after_close_chk: assert property (@(posedge clk_s) disable iff (!rst_n)
        !prov_en |-> !gate_ack);

    // R9
    drive_follows_cfg_chk: assert property (@(posedge clk_s) disable iff (!rst_n)
        cfg_we |=> (drive_hi == $past(cfg_drive)));

endmodule

bind hfclk_req_ctrl hcr_checker u_chk (
    .clk_s     (clk_s),
    .rst_n     (rst_n),
    .req_in    (req_in),
    .cfg_we    (cfg_we),
    .cfg_drive (cfg_drive),
    .prov_en   (prov_en),
    .drive_hi  (drive_hi),
    .open_req  (open_req),
    .gate_ack  (gate_ack),
    .state_q   (state_q)
);

// File: tb/hfclk_req_ctrl_bench.sv
`timescale 1ns/1ps
module hfclk_req_ctrl_bench;

    localparam int NSEC     = 2;
    localparam int SETTLE_W = 9;
    localparam int DEF_CNT  = 328;

    logic                clk_s = 1'b0;
    logic                clk_hf = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_in = 1'b0;
    logic [NSEC-1:0]     sleep_req = '0;
    logic                cfg_we = 1'b0;
    logic [SETTLE_W-1:0] cfg_settle = '0;
    logic                cfg_drive = 1'b0;
    logic [NSEC-1:0]     cfg_sleep_en = '0;
    logic                prov_en;
    logic                hf_clk_out;
    logic                drive_hi;

    int nvec = 0;
    int nbad = 0;
    int pulses = 0;
    int runts = 0;
    realtime t_rise = 0.0;

    hfclk_req_ctrl #(
        .NSEC           (NSEC),
        .SETTLE_W       (SETTLE_W),
        .DEFAULT_SETTLE (DEF_CNT)
    ) u_hfclk_req_ctrl (
        .clk_s        (clk_s),
        .clk_hf       (clk_hf),
        .rst_n        (rst_n),
        .req_in       (req_in),
        .sleep_req    (sleep_req),
        .cfg_we       (cfg_we),
        .cfg_settle   (cfg_settle),
        .cfg_drive    (cfg_drive),
        .cfg_sleep_en (cfg_sleep_en),
        .prov_en      (prov_en),
        .hf_clk_out   (hf_clk_out),
        .drive_hi     (drive_hi)
    );

    // 250 MHz high-frequency clock; slow timebase scaled down for simulation
    initial forever #2 clk_hf = ~clk_hf;
    initial begin
        #1;
        forever #40 clk_s = ~clk_s;
    end

    always @(posedge hf_clk_out) if (rst_n) begin
        pulses++;
        t_rise = $realtime;
    end
    always @(negedge hf_clk_out) if (rst_n && pulses > 0) begin
        if (($realtime - t_rise) < 1.9 || ($realtime - t_rise) > 2.1) runts++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_src(input int src, input logic v);
        case (src)
            0:       req_in       = v;
            1:       sleep_req[0] = v;
            default: sleep_req[1] = v;
        endcase
    endtask

    task automatic cfg_write(input int n, input logic drv, input logic [NSEC-1:0] en);
        @(negedge clk_s);
        cfg_we       = 1'b1;
        cfg_settle   = SETTLE_W'(n);
        cfg_drive    = drv;
        cfg_sleep_en = en;
        @(negedge clk_s);
        cfg_we = 1'b0;
    endtask

    task automatic run_req(input int src, input int n_eff, input string tg);
        int p0;
        int q;
        @(negedge clk_s);
        set_src(src, 1'b1);
        #1;
        chk(prov_en === 1'b1, "R1 enable same cycle", int'(prov_en), 1);
        p0 = pulses;
        repeat (n_eff) @(posedge clk_s);
        @(negedge clk_s);
        chk(pulses == p0, {tg, " no clock before expiry"}, pulses - p0, 0);
        @(posedge clk_s);
        @(negedge clk_s);
        chk(pulses > p0, {tg, " clock after expiry"}, pulses - p0, 1);
        repeat (3) @(negedge clk_s);
        set_src(src, 1'b0);
        @(posedge clk_s);
        @(posedge clk_s);
        #20;
        q = pulses;
        @(posedge clk_s);
        @(negedge clk_s);
        chk(pulses == q, "R7 gate shut", pulses - q, 0);
        chk(prov_en === 1'b1, "R7 enable held", int'(prov_en), 1);
        @(posedge clk_s);
        @(negedge clk_s);
        chk(prov_en === 1'b0, "R7 enable dropped", int'(prov_en), 0);
    endtask

    initial begin
        #600000;
        nbad++;
        $display("FAIL watchdog expired, run hung");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        int p0;
        repeat (3) @(negedge clk_s);
        rst_n = 1'b1;
        @(negedge clk_s);
        chk(prov_en === 1'b0, "R1 reset enable low", int'(prov_en), 0);
        chk(drive_hi === 1'b0, "R9 reset low drive", int'(drive_hi), 0);
        chk(pulses == 0, "R3 reset no clock", pulses, 0);

        // R4: reset count is the worst case
        run_req(0, DEF_CNT, "R4");

        // R2: sleep requests are ignored while disabled
        @(negedge clk_s);
        sleep_req = 2'b11;
        #1;
        chk(prov_en === 1'b0, "R2 disabled sleep request", int'(prov_en), 0);
        p0 = pulses;
        repeat (10) @(posedge clk_s);
        @(negedge clk_s);
        chk(pulses == p0, "R2 no clock while disabled", pulses - p0, 0);
        chk(prov_en === 1'b0, "R2 enable stays low", int'(prov_en), 0);
        sleep_req = 2'b00;

        // R9: drive bit follows writes
        cfg_write(7, 1'b1, 2'b00);
        chk(drive_hi === 1'b1, "R9 high drive", int'(drive_hi), 1);
        cfg_write(7, 1'b0, 2'b10);
        chk(drive_hi === 1'b0, "R9 low drive", int'(drive_hi), 0);
        @(negedge clk_s);
        sleep_req[0] = 1'b1;
        #1;
        chk(prov_en === 1'b0, "R2 line 0 not enabled", int'(prov_en), 0);
        sleep_req[0] = 1'b0;

        // R3, R5: sweep counts and sources, each twice for reload
        for (int n = 0; n < 6; n++) begin
            cfg_write(n, n[0], 2'b11);
            chk(drive_hi === n[0], "R9 drive in sweep", int'(drive_hi), n[0]);
            for (int s = 0; s < 3; s++) begin
                run_req(s, (n == 0) ? 1 : n, "R3");
                run_req(s, (n == 0) ? 1 : n, "R5");
            end
        end

        // R6: withdrawal during settling
        cfg_write(4, 1'b0, 2'b11);
        @(negedge clk_s);
        req_in = 1'b1;
        p0 = pulses;
        @(posedge clk_s);
        @(negedge clk_s);
        req_in = 1'b0;
        @(posedge clk_s);
        @(negedge clk_s);
        chk(prov_en === 1'b0, "R6 abort to idle", int'(prov_en), 0);
        repeat (8) @(posedge clk_s);
        @(negedge clk_s);
        chk(pulses == p0, "R6 gate never opened", pulses - p0, 0);

        // R6: withdrawal sampled on the expiry edge
        cfg_write(3, 1'b0, 2'b11);
        @(negedge clk_s);
        req_in = 1'b1;
        p0 = pulses;
        repeat (3) @(posedge clk_s);
        @(negedge clk_s);
        req_in = 1'b0;
        @(posedge clk_s);
        @(negedge clk_s);
        chk(prov_en === 1'b0, "R6 abort wins over expiry", int'(prov_en), 0);
        repeat (6) @(posedge clk_s);
        @(negedge clk_s);
        chk(pulses == p0, "R6 no clock on coincident edge", pulses - p0, 0);

        // R8: no runt pulses over the whole run
        chk(runts == 0, "R8 runt pulses", runts, 0);
        chk(pulses > 0, "R8 clock was seen", pulses, 1);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule